// File: doc/BRIEF.md
# LSB-First Word Serializer with Internal Wrap

This block turns a stream of 10-bit parallel words into a serial bit stream. A word is presented on `tx_word_i` and captured on each rising edge of the byte clock. A bit clock runs at exactly ten times the byte clock rate and is edge-aligned with it. The block shifts each captured word out one bit per bit-clock cycle, least significant bit first. Words follow one another with no idle bit between them.

A wrap control, `lpbk_i`, lets the link be tested without the external medium. While wrap is off, the serial stream drives `ser_o`, and the receiver-side output `rx_ser_o` passes the external serial input `rx_ser_i` through. While wrap is on, `ser_o` is held at logic 0 and `rx_ser_o` carries the block's own transmit stream. The wrap setting is sampled only when a new word loads. Each word therefore travels entirely on one path.

Top module: `lsb_wrap_serializer`

## Requirements
- R1: A word present on `tx_word_i` at a byte-clock rising edge loads into the shift register on the next bit-clock rising edge. Its bit 0 appears on the serial path right after that load edge.
- R2: Each word occupies exactly 10 consecutive bit-clock cycles. The next word's bit 0 follows the previous word's bit 9 in the very next bit cycle, with no gap.
- R3: The bits of a word leave in the order bit 0 (LSB) through bit 9 (MSB), one per bit-clock cycle.
- R4: While the active path is external (wrap off), `ser_o` carries the serial stream, and `rx_ser_o` equals `rx_ser_i` combinationally.
- R5: While the active path is wrap, `ser_o` is held at constant logic 0.
- R6: While the active path is wrap, `rx_ser_o` carries the transmit stream bit by bit and ignores `rx_ser_i`.
- R7: The value of `lpbk_i` is sampled only on the bit-clock edge that loads a word. A change of `lpbk_i` in the middle of a word leaves that word's remaining bits on the path it started on.
- R8: While `rst_ni` is low (asynchronous, active low), the shift register is clear, `ser_o` is 0, and the active path is external. No word loads until the first byte-clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| byte_clk_i | input | 1 | Word-rate reference clock; words are captured on its rising edge |
| bit_clk_i | input | 1 | Bit-rate clock, ten times `byte_clk_i`, edge-aligned with it |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tx_word_i | input | 10 | Parallel word to transmit |
| lpbk_i | input | 1 | 1 selects internal wrap, 0 selects normal operation; applied per word |
| rx_ser_i | input | 1 | External serial input for the receiver side |
| ser_o | output | 1 | External serial output; 0 while wrap is active |
| rx_ser_o | output | 1 | Serial stream handed to the receiver: `rx_ser_i` or the wrapped transmit stream |

## Verification
The bench checks every bit of a back-to-back word stream at its exact bit cycle. A load that came one cycle late or early would shift every check by a bit, and MSB-first order would reverse the observed pattern. It also moves `lpbk_i` in the middle of a word. A design that switched paths immediately would leak the tail of a word onto the wrong output, or drive a nonzero level on `ser_o` during wrap. It asserts reset while a 1 bit is on the line, so a synchronous or missing reset shows up as a stale high output.

// File: rtl/lsbser_pkg.sv
package lsbser_pkg;
  localparam int unsigned WORD_W_DEF = 10;

  typedef enum logic {
    PATH_EXT  = 1'b0,
    PATH_WRAP = 1'b1
  } path_e;
endpackage

// File: rtl/lsbser_word_latch.sv
module lsbser_word_latch #(
  parameter int unsigned WORD_W = lsbser_pkg::WORD_W_DEF
) (
  input  logic              byte_clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] word_o,
  output logic              tog_o
);
  logic [WORD_W-1:0] word_q;
  logic              tog_q;

  // tog_q flips once per captured word; the bit domain detects the edge
  always_ff @(posedge byte_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      tog_q  <= 1'b0;
    end else begin
      word_q <= word_i;
      tog_q  <= ~tog_q;
    end
  end

  assign word_o = word_q;
  assign tog_o  = tog_q;
endmodule

// File: rtl/lsbser_bit_shifter.sv
module lsbser_bit_shifter
  import lsbser_pkg::*;
#(
  parameter int unsigned WORD_W = WORD_W_DEF
) (
  input  logic              bit_clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  input  logic              tog_i,
  input  logic              lpbk_i,
  output logic              bit_o,
  output path_e             path_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic              seen_q;
  logic [WORD_W-1:0] shreg_q;
  logic [CNT_W-1:0]  cnt_q;
  path_e             path_q;
  logic              load_w;

  // clocks are edge-aligned: the toggle is stable by the next bit edge
  assign load_w = tog_i ^ seen_q;

  always_ff @(posedge bit_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q  <= 1'b0;
      shreg_q <= '0;
      cnt_q   <= LAST;
      path_q  <= PATH_EXT;
    end else begin
      seen_q <= tog_i;
      if (load_w) begin
        shreg_q <= word_i;
        cnt_q   <= '0;
        path_q  <= lpbk_i ? PATH_WRAP : PATH_EXT;
      end else begin
        shreg_q <= shreg_q >> 1;
        if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign bit_o  = shreg_q[0];
  assign path_o = path_q;

  assert_load_word_R1: assert property (@(posedge bit_clk_i) disable iff (!rst_ni)
    load_w |=> shreg_q == $past(word_i));

  assert_load_on_boundary_R2: assert property (@(posedge bit_clk_i) disable iff (!rst_ni)
    load_w |-> cnt_q == LAST);

  assert_lsb_shift_R3: assert property (@(posedge bit_clk_i) disable iff (!rst_ni)
    !load_w |=> shreg_q == ($past(shreg_q) >> 1));

  assert_path_hold_R7: assert property (@(posedge bit_clk_i) disable iff (!rst_ni)
    !load_w |=> $stable(path_q));
endmodule

// File: rtl/lsbser_wrap_mux.sv
module lsbser_wrap_mux
  import lsbser_pkg::*;
(
  input  logic  bit_i,
  input  path_e path_i,
  input  logic  rx_ser_i,
  output logic  ser_o,
  output logic  rx_ser_o
);
  always_comb begin
    if (path_i == PATH_WRAP) begin
      ser_o    = 1'b0;
      rx_ser_o = bit_i;
    end else begin
      ser_o    = bit_i;
      rx_ser_o = rx_ser_i;
    end
  end
endmodule

// File: rtl/lsb_wrap_serializer.sv
module lsb_wrap_serializer
  import lsbser_pkg::*;
#(
  parameter int unsigned WORD_W = WORD_W_DEF
) (
  input  logic              byte_clk_i,
  input  logic              bit_clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] tx_word_i,
  input  logic              lpbk_i,
  input  logic              rx_ser_i,
  output logic              ser_o,
  output logic              rx_ser_o
);
  logic [WORD_W-1:0] word_w;
  logic              tog_w;
  logic              bit_w;
  path_e             path_w;

  lsbser_word_latch #(.WORD_W(WORD_W)) u_latch (
    .byte_clk_i(byte_clk_i),
    .rst_ni    (rst_ni),
    .word_i    (tx_word_i),
    .word_o    (word_w),
    .tog_o     (tog_w)
  );

  lsbser_bit_shifter #(.WORD_W(WORD_W)) u_shift (
    .bit_clk_i(bit_clk_i),
    .rst_ni   (rst_ni),
    .word_i   (word_w),
    .tog_i    (tog_w),
    .lpbk_i   (lpbk_i),
    .bit_o    (bit_w),
    .path_o   (path_w)
  );

  lsbser_wrap_mux u_mux (
    .bit_i   (bit_w),
    .path_i  (path_w),
    .rx_ser_i(rx_ser_i),
    .ser_o   (ser_o),
    .rx_ser_o(rx_ser_o)
  );

  assert_static_out_R5: assert property (@(posedge bit_clk_i) disable iff (!rst_ni)
    (path_w == PATH_WRAP && $past(path_w == PATH_WRAP)) |-> ($stable(ser_o) && !ser_o));
endmodule

// File: tb/lsb_wrap_serializer_bench.sv
module lsb_wrap_serializer_bench;
  localparam int W = 10;
  localparam int NV = 8;
  // {lpbk, word, external rx pattern}
  localparam logic [2*W:0] VEC [NV] = '{
    {1'b0, 10'h155, 10'h0F3},
    {1'b0, 10'h2AA, 10'h35A},
    {1'b1, 10'h3C1, 10'h3FF},
    {1'b1, 10'h0F0, 10'h000},
    {1'b0, 10'h201, 10'h2C7},
    {1'b1, 10'h1FE, 10'h155},
    {1'b0, 10'h33C, 10'h0A5},
    {1'b0, 10'h3FF, 10'h18E}
  };

  logic byte_clk = 0, bit_clk = 0, rst_ni = 0;
  logic [W-1:0] tx_word = '0;
  logic lpbk = 0, rx_ser = 0;
  logic ser, rx_out;
  int n_run = 0, n_fail = 0;

  lsb_wrap_serializer u_lsb_wrap_serializer (
    .byte_clk_i(byte_clk), .bit_clk_i(bit_clk), .rst_ni(rst_ni),
    .tx_word_i(tx_word), .lpbk_i(lpbk), .rx_ser_i(rx_ser),
    .ser_o(ser), .rx_ser_o(rx_out)
  );

  // 100 MHz bit clock, byte clock at one tenth, rising edges aligned
  initial begin
    int ph = 0;
    forever begin
      bit_clk = 1'b1;
      if (ph == 0) byte_clk = 1'b1;
      if (ph == 5) byte_clk = 1'b0;
      #5 bit_clk = 1'b0;
      #5 ph = (ph + 1) % 10;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R8: reset state
    rx_ser = 1'b1;
    #23;
    chk("R8", ser, 1'b0);
    chk("R8", rx_out, 1'b1);
    @(negedge bit_clk);
    rst_ni = 1'b1;
    @(negedge byte_clk);
    tx_word = VEC[0][2*W-1:W];
    lpbk    = VEC[0][2*W];
    @(posedge byte_clk);
    for (int w = 0; w < NV; w++) begin
      logic         lp;
      logic [W-1:0] wd, ex;
      logic         nlp;
      lp  = VEC[w][2*W];
      wd  = VEC[w][2*W-1:W];
      ex  = VEC[w][W-1:0];
      nlp = (w + 1 < NV) ? VEC[w+1][2*W] : 1'b0;
      for (int j = 0; j < W; j++) begin
        string tg;
        @(posedge bit_clk);
        #2;
        rx_ser = ex[j];
        #1;
        if (j >= 5 && nlp != lp) tg = "R7";
        else if (lp) tg = "R5";
        else if (j == 0) tg = "R1";
        else if (j == 9) tg = "R2";
        else tg = "R3";
        chk(tg, ser, lp ? 1'b0 : wd[j]);
        chk(lp ? "R6" : "R4", rx_out, lp ? wd[j] : ex[j]);
        if (j == 4) begin
          tx_word = (w + 1 < NV) ? VEC[w+1][2*W-1:W] : 10'h3FF;
          lpbk    = nlp;
        end
      end
    end
    // R2: next word follows without a gap
    @(posedge bit_clk);
    #2;
    chk("R2", ser, 1'b1);
    // R8: asynchronous reset while a 1 is on the line
    rst_ni = 1'b0;
    rx_ser = 1'b0;
    #1;
    chk("R8", ser, 1'b0);
    chk("R8", rx_out, 1'b0);
    @(posedge bit_clk);
    #2;
    chk("R8", ser, 1'b0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule